// File: doc/BRIEF.md
# Logical-Order Block Reassembly Buffer

This block takes fixed-size data blocks that arrive in any order, each carrying its logical block number, and puts them back in file order. Each block is written as a run of consecutive beats that share one block number. The block is stored in the slot picked by the low bits of that number. Storage is a memory of `SLOTS` block slots. It is used as a cyclic window whose start is the base block number. When the block at the window head is complete, it streams out beat by beat. After it drains, the base moves up by one, so a file of any length passes through a small buffer.

A `start` pulse loads the first block number of the file and the number of blocks. Both streaming edges use valid/ready. On the input side a beat transfers only on a cycle where `in_valid` and `in_ready` are both high. The upstream side must hold the block number and the data steady until that cycle. On the output side a beat leaves only when `out_valid` and `out_ready` are both high. While `out_ready` is low, the offered beat and its markers do not change. The two sides run independently on one clock. Error flags and the done pulse are plain one-cycle outputs.

Sizing: the production sizing is 256 slots of 4 KB with 16-byte beats. The defaults here are small so the array stays compact. `SLOTS` and `BEATS` must be powers of two, each at least 2.

Top module: `blk_reorder_buf`

## Requirements
- R1: Every block is stored by its block number, whatever its arrival order. The output carries each block's beats unchanged, in beat order.
- R2: Blocks leave in strictly ascending block-number order. `out_valid` stays low while the head block (number = base) has not received all `BEATS` beats, even if later blocks are complete.
- R3: Input beats are accepted on the same cycles that output beats drain.
- R4: A block number is inside the window when base ≤ number < base + `SLOTS` and number < first + count. For a number outside the window, `in_ready` stays low, `err_oow` is high the next cycle, and no stored data changes.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and the markers hold their values into the next cycle.
- R6: `out_first` is high on beat 0 of each block. `out_blk_end` is high on beat `BEATS`-1.
- R7: `start` clears all slots and loads base and count. `out_file_end` marks the last beat of the final block. `done` pulses for one cycle after that beat transfers, and afterwards `in_ready` is low.
- R8: A block written to a slot that already holds a complete block has its beats accepted but discarded. `err_dup` is high the cycle after each such beat, and the original data is still emitted.
- R9: Once the head block drains, number base + `SLOTS` becomes acceptable, so files longer than the buffer pass through.
- R10: After reset, `out_valid`, `in_ready`, `done`, `err_oow` and `err_dup` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Load a new file and clear the window |
| start_lbn | input | LBN_W | First block number of the file |
| blk_count | input | LBN_W | Number of blocks in the file |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Input beat can be taken |
| in_lbn | input | LBN_W | Block number of the offered beat |
| in_data | input | BEAT_W | Input beat data |
| out_valid | output | 1 | Output beat offered |
| out_ready | input | 1 | Downstream takes the beat |
| out_data | output | BEAT_W | Output beat data |
| out_first | output | 1 | Beat 0 of a block |
| out_blk_end | output | 1 | Last beat of a block |
| out_file_end | output | 1 | Last beat of the file |
| done | output | 1 | One-cycle pulse after the file's final beat |
| err_oow | output | 1 | Out-of-window block number was presented |
| err_dup | output | 1 | Beat aimed at an occupied slot was discarded |

## Verification
The bench builds the buffer with 4 slots of 4 beats, 32-bit beats and 16-bit block numbers. It then sends a 10-block file, so the window has to slide more than twice before the file ends. With so few slots, the window edge is reached within a handful of blocks. This exposes the out-of-window refusal, the stall of a head block that is still incomplete, and reuse of a freed slot. Random stalls on the output side make drains overlap with writes, and they hold beats under back-pressure.

// File: rtl/rob_pkg.sv
package rob_pkg;
  // Per-beat framing markers carried beside the output data.
  typedef struct packed {
    logic first;
    logic blk_end;
    logic file_end;
  } rob_mark_t;
endpackage

// File: rtl/rob_slot_flags.sv
module rob_slot_flags #(
  parameter int SLOTS  = 4,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_all,
  input  logic              set_en,
  input  logic [SLOT_W-1:0] set_idx,
  input  logic              drop_en,
  input  logic [SLOT_W-1:0] drop_idx,
  output logic [SLOTS-1:0]  flags
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
    end else if (clr_all) begin
      flags <= '0;
    end else begin
      if (set_en)  flags[set_idx]  <= 1'b1;
      if (drop_en) flags[drop_idx] <= 1'b0;
    end
  end

  // R2: a slot is only completed while empty, and only a full slot drains
  p_set_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |-> !flags[set_idx]);
  p_drop_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    drop_en |-> flags[drop_idx]);
endmodule

// File: rtl/rob_store.sv
module rob_store #(
  parameter int BEAT_W = 32,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [BEAT_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [BEAT_W-1:0] rdata
);
  logic [BEAT_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rob_admit.sv
module rob_admit #(
  parameter int SLOTS  = 4,
  parameter int BEATS  = 4,
  parameter int BEAT_W = 32,
  parameter int LBN_W  = 16,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int BIDX_W = $clog2(BEATS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     active,
  input  logic [LBN_W-1:0]         base,
  input  logic [LBN_W-1:0]         remaining,
  input  logic [SLOTS-1:0]         flags,
  input  logic                     in_valid,
  input  logic [LBN_W-1:0]         in_lbn,
  input  logic [BEAT_W-1:0]        in_data,
  output logic                     in_ready,
  output logic                     we,
  output logic [SLOT_W+BIDX_W-1:0] waddr,
  output logic [BEAT_W-1:0]        wdata,
  output logic                     set_en,
  output logic [SLOT_W-1:0]        set_idx,
  output logic                     err_oow,
  output logic                     err_dup
);
  logic [LBN_W-1:0]  off;
  logic              in_win;
  logic [SLOT_W-1:0] slot;
  logic [BIDX_W-1:0] wr_beat;
  logic              fire, dup, wr_last;

  assign off     = in_lbn - base;
  assign in_win  = (off < LBN_W'(SLOTS)) && (off < remaining);
  assign slot    = in_lbn[SLOT_W-1:0];
  assign in_ready = active && in_win;
  assign fire    = in_valid && in_ready;
  assign dup     = flags[slot];
  assign wr_last = (wr_beat == BIDX_W'(BEATS-1));

  assign we      = fire && !dup;
  assign waddr   = {slot, wr_beat};
  assign wdata   = in_data;
  assign set_en  = fire && !dup && wr_last;
  assign set_idx = slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_beat <= '0;
      err_oow <= 1'b0;
      err_dup <= 1'b0;
    end else begin
      err_oow <= in_valid && active && !in_win;
      err_dup <= fire && dup;
      if (start)     wr_beat <= '0;
      else if (fire) wr_beat <= wr_last ? '0 : wr_beat + 1'b1;
    end
  end

  // R4: the window error only follows a refused offer
  p_oow_refused_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err_oow |-> $past(in_valid && !in_ready));
  // R8: the duplicate error only follows an accepted beat
  p_dup_taken_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_dup |-> $past(in_valid && in_ready));
endmodule

// File: rtl/rob_drain.sv
module rob_drain
  import rob_pkg::*;
#(
  parameter int SLOTS  = 4,
  parameter int BEATS  = 4,
  parameter int LBN_W  = 16,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int BIDX_W = $clog2(BEATS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [LBN_W-1:0]         start_lbn,
  input  logic [LBN_W-1:0]         blk_count,
  input  logic [SLOTS-1:0]         flags,
  input  logic                     out_ready,
  output logic                     out_valid,
  output logic [SLOT_W+BIDX_W-1:0] raddr,
  output rob_mark_t                mark,
  output logic [LBN_W-1:0]         base,
  output logic [LBN_W-1:0]         remaining,
  output logic                     active,
  output logic                     drop_en,
  output logic [SLOT_W-1:0]        drop_idx,
  output logic                     done
);
  logic [BIDX_W-1:0] rd_beat;
  logic              fire, rd_last;

  assign drop_idx  = base[SLOT_W-1:0];
  assign out_valid = active && flags[drop_idx];
  assign fire      = out_valid && out_ready;
  assign rd_last   = (rd_beat == BIDX_W'(BEATS-1));
  assign raddr     = {drop_idx, rd_beat};
  assign drop_en   = fire && rd_last;

  assign mark.first    = (rd_beat == '0);
  assign mark.blk_end  = rd_last;
  assign mark.file_end = rd_last && (remaining == LBN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base      <= '0;
      remaining <= '0;
      active    <= 1'b0;
      rd_beat   <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        base      <= start_lbn;
        remaining <= blk_count;
        active    <= (blk_count != '0);
        rd_beat   <= '0;
      end else if (fire) begin
        if (rd_last) begin
          rd_beat   <= '0;
          base      <= base + 1'b1;
          remaining <= remaining - 1'b1;
          if (remaining == LBN_W'(1)) begin
            active <= 1'b0;
            done   <= 1'b1;
          end
        end else begin
          rd_beat <= rd_beat + 1'b1;
        end
      end
    end
  end

  // R9: the window slides by exactly one block per drained block
  p_base_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && rd_last && !start) |=> base == $past(base) + 1'b1);
  // R7: after the done pulse nothing more is offered or taken
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !active && !out_valid);
endmodule

// File: rtl/blk_reorder_buf.sv
module blk_reorder_buf
  import rob_pkg::*;
#(
  parameter int SLOTS  = 4,
  parameter int BEATS  = 4,
  parameter int BEAT_W = 32,
  parameter int LBN_W  = 16,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int BIDX_W = $clog2(BEATS),
  localparam int DEPTH  = SLOTS * BEATS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LBN_W-1:0]  start_lbn,
  input  logic [LBN_W-1:0]  blk_count,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [LBN_W-1:0]  in_lbn,
  input  logic [BEAT_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BEAT_W-1:0] out_data,
  output logic              out_first,
  output logic              out_blk_end,
  output logic              out_file_end,
  output logic              done,
  output logic              err_oow,
  output logic              err_dup
);
  logic [SLOTS-1:0]         flags;
  logic [LBN_W-1:0]         base, remaining;
  logic                     active;
  logic                     we, set_en, drop_en;
  logic [SLOT_W+BIDX_W-1:0] waddr, raddr;
  logic [BEAT_W-1:0]        wdata;
  logic [SLOT_W-1:0]        set_idx, drop_idx;
  rob_mark_t                mark;

  rob_slot_flags #(.SLOTS(SLOTS)) u_flags (
    .clk(clk), .rst_n(rst_n), .clr_all(start),
    .set_en(set_en), .set_idx(set_idx),
    .drop_en(drop_en), .drop_idx(drop_idx), .flags(flags));

  rob_admit #(.SLOTS(SLOTS), .BEATS(BEATS), .BEAT_W(BEAT_W), .LBN_W(LBN_W)) u_admit (
    .clk(clk), .rst_n(rst_n), .start(start), .active(active),
    .base(base), .remaining(remaining), .flags(flags),
    .in_valid(in_valid), .in_lbn(in_lbn), .in_data(in_data), .in_ready(in_ready),
    .we(we), .waddr(waddr), .wdata(wdata),
    .set_en(set_en), .set_idx(set_idx),
    .err_oow(err_oow), .err_dup(err_dup));

  rob_store #(.BEAT_W(BEAT_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(raddr), .rdata(out_data));

  rob_drain #(.SLOTS(SLOTS), .BEATS(BEATS), .LBN_W(LBN_W)) u_drain (
    .clk(clk), .rst_n(rst_n), .start(start),
    .start_lbn(start_lbn), .blk_count(blk_count),
    .flags(flags), .out_ready(out_ready), .out_valid(out_valid),
    .raddr(raddr), .mark(mark), .base(base), .remaining(remaining),
    .active(active), .drop_en(drop_en), .drop_idx(drop_idx), .done(done));

  assign out_first    = mark.first;
  assign out_blk_end  = mark.blk_end;
  assign out_file_end = mark.file_end;

  // R5: a stalled output beat holds
  p_hold_stalled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !start) |=>
      out_valid && $stable(out_data) && $stable(out_first) && $stable(out_blk_end));
endmodule

// File: tb/blk_reorder_buf_test.sv
module blk_reorder_buf_test;
  localparam int SLOTS = 4, BEATS = 4, BEAT_W = 32, LBN_W = 16;
  localparam int FIRST = 100, NBLK = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0;
  logic [LBN_W-1:0] start_lbn = '0, blk_count = '0;
  logic in_valid = 1'b0, in_ready;
  logic [LBN_W-1:0] in_lbn = '0;
  logic [BEAT_W-1:0] in_data = '0;
  logic out_valid, out_ready = 1'b0;
  logic [BEAT_W-1:0] out_data;
  logic out_first, out_blk_end, out_file_end, done, err_oow, err_dup;

  int n_chk = 0, n_bad = 0;
  logic [BEAT_W-1:0] exp_q[$];
  int popped = 0, overlap = 0;
  bit rnd_en = 0, pend_done = 0, seen_done = 0;
  logic [7:0] lfsr = 8'h5A;

  always #4 clk = ~clk;  // 125 MHz

  blk_reorder_buf #(.SLOTS(SLOTS), .BEATS(BEATS), .BEAT_W(BEAT_W), .LBN_W(LBN_W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_lbn(start_lbn), .blk_count(blk_count),
    .in_valid(in_valid), .in_ready(in_ready), .in_lbn(in_lbn), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_first(out_first), .out_blk_end(out_blk_end), .out_file_end(out_file_end),
    .done(done), .err_oow(err_oow), .err_dup(err_dup));

  task automatic check(input string req, input logic [BEAT_W-1:0] act, input logic [BEAT_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [BEAT_W-1:0] pat(input int lbn, input int b, input bit alt);
    logic [15:0] hi;
    hi = alt ? ~16'(lbn) : 16'(lbn);
    return {hi, 16'(b)};
  endfunction

  task automatic wr_range(input int lbn, input int b0, input int b1, input bit alt);
    for (int b = b0; b <= b1; b++) begin
      bit ok;
      in_valid = 1'b1;
      in_lbn   = LBN_W'(lbn);
      in_data  = pat(lbn, b, alt);
      forever begin
        @(negedge clk); ok = in_ready;
        @(posedge clk); #1;
        if (ok) break;
      end
    end
    in_valid = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // downstream readiness
  initial begin
    forever begin
      @(posedge clk); #1;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready = rnd_en ? (lfsr[0] | lfsr[3]) : 1'b0;
    end
  end

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (pend_done) begin
        check("R7 done pulse", BEAT_W'(done), 1);
        check("R7 ready low after done", BEAT_W'(in_ready), 0);
        pend_done = 0; seen_done = 1;
      end
      if (out_valid && out_ready) begin
        logic [BEAT_W-1:0] e;
        int b;
        if (in_valid && in_ready) overlap++;
        if (exp_q.size() == 0) begin
          check("R2 unexpected beat", out_data, '1);
        end else begin
          e = exp_q.pop_front();
          b = int'(e[15:0]);
          popped++;
          check("R1 R2 R9 beat data", out_data, e);
          check("R6 first marker", BEAT_W'(out_first), BEAT_W'(b == 0));
          check("R6 block end marker", BEAT_W'(out_blk_end), BEAT_W'(b == BEATS-1));
          check("R7 file end marker", BEAT_W'(out_file_end),
                BEAT_W'(exp_q.size() == 0));
          if (exp_q.size() == 0) pend_done = 1;
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    @(negedge clk);
    check("R10 out_valid at reset", BEAT_W'(out_valid), 0);
    check("R10 in_ready at reset", BEAT_W'(in_ready), 0);
    check("R10 done at reset", BEAT_W'(done), 0);
    check("R10 errors at reset", BEAT_W'({err_oow, err_dup}), 0);
    @(posedge clk); #1; rst_n = 1'b1;

    for (int l = FIRST; l < FIRST + NBLK; l++)
      for (int b = 0; b < BEATS; b++) exp_q.push_back(pat(l, b, 0));

    @(posedge clk); #1;
    start = 1'b1; start_lbn = LBN_W'(FIRST); blk_count = LBN_W'(NBLK);
    @(posedge clk); #1; start = 1'b0;
    @(negedge clk);
    check("R7 nothing offered after start", BEAT_W'(out_valid), 0);

    // later block first, head only partly
    @(posedge clk); #1;
    wr_range(FIRST + 1, 0, BEATS - 1, 0);
    wr_range(FIRST, 0, 1, 0);
    @(negedge clk);
    check("R2 head incomplete holds output", BEAT_W'(out_valid), 0);
    @(posedge clk); #1;
    wr_range(FIRST, 2, BEATS - 1, 0);
    @(negedge clk);
    check("R2 head complete offers", BEAT_W'(out_valid), 1);
    check("R1 head beat 0", out_data, pat(FIRST, 0, 0));

    // back-pressure hold
    repeat (3) begin
      @(negedge clk);
      check("R5 held valid", BEAT_W'(out_valid), 1);
      check("R5 held data", out_data, pat(FIRST, 0, 0));
      check("R5 held first", BEAT_W'(out_first), 1);
    end

    // duplicate of a complete block
    @(posedge clk); #1;
    wr_range(FIRST + 1, 0, BEATS - 1, 1);
    @(negedge clk);
    check("R8 duplicate flagged", BEAT_W'(err_dup), 1);

    // out of window (base 100, 4 slots)
    @(posedge clk); #1;
    in_valid = 1'b1; in_lbn = LBN_W'(FIRST + SLOTS); in_data = '1;
    @(negedge clk);
    check("R4 ready low outside window", BEAT_W'(in_ready), 0);
    @(posedge clk); #1;
    @(negedge clk);
    check("R4 window error", BEAT_W'(err_oow), 1);
    check("R4 head data untouched", out_data, pat(FIRST, 0, 0));
    in_valid = 1'b0;
    @(posedge clk); #1;

    rnd_en = 1;
    wr_range(FIRST + 3, 0, BEATS - 1, 0);
    wr_range(FIRST + 2, 0, BEATS - 1, 0);
    wr_range(FIRST + 5, 0, BEATS - 1, 0);
    wr_range(FIRST + 4, 0, BEATS - 1, 0);
    check("R9 slid window before block 104 taken", BEAT_W'(popped >= BEATS), 1);
    wr_range(FIRST + 7, 0, BEATS - 1, 0);
    wr_range(FIRST + 6, 0, BEATS - 1, 0);
    wr_range(FIRST + 9, 0, BEATS - 1, 0);
    wr_range(FIRST + 8, 0, BEATS - 1, 0);

    while (!seen_done) @(posedge clk);
    check("R1 all beats emitted", BEAT_W'(popped), BEAT_W'(NBLK * BEATS));
    check("R3 writes overlapped drains", BEAT_W'(overlap > 0), 1);
    summary();
    $finish;
  end
endmodule